// File: doc/BRIEF.md
# USB Root Port Status and Control Register

This block holds the status and control word of each root port of a full-speed USB host controller. Every port owns one 16-bit register on a small byte-addressed register bus. The register mixes three kinds of field. Live line-state bits follow the port PHY directly. Sticky change flags record events until software clears them by writing a one. Control bits drive the PHY's enable, reset and suspend inputs.

Software reads a port's word to find out what happened since it last looked. It acknowledges events by writing ones back to the change flags. Writing zeros leaves those flags untouched, so a read-modify-write of the control bits loses no event. Two conditions remove a port's enable without any help from software: a disconnect, and the onset of an over-current condition.

The port count, the byte address of the first port and the spacing between ports are parameters. The defaults give two ports at byte addresses 16 and 18. Reads are combinational from the addressed port. Writes take effect at the clock edge.

Top module: `usb_port_sc_regs`

## Requirements
- R1: Bits 4 and 6 show the current levels of the addressed port's D+ line and resume-signalling input. Bits 5 and 8 show its D- line and low-speed-detect input. None of these bits is changed by a write.
- R2: Bit 0 shows the connect input as registered at the last clock edge, and writes do not change it. Bit 1 is set at any edge where the connect input differs from bit 0. Bit 1 is cleared by writing 1, is unaffected by writing 0, and a set in the same cycle as a clear leaves it set.
- R3: Bit 2 is the port enable and drives `port_en_o`. Software writes set or clear it. A disconnect (bit 0 is 1 and the connect input is 0) or a rising over-current input (bit 10 is 0 and the input is 1) clears it at that edge, overriding a write.
- R4: Bit 3 is set at any edge where bit 2 changes value, for any cause. Writing 1 clears it, writing 0 leaves it alone, and a set wins over a clear in the same cycle.
- R5: Bit 7 of a mapped port always reads 1. Bits 15 to 13 always read 0, whatever was written.
- R6: Bit 9 (reset) and bit 12 (suspend) take the written value and drive `port_rst_o` and `port_susp_o`.
- R7: Bit 10 shows the over-current input as registered at the last edge, and writes do not change it. Bit 11 is set at any edge where that input differs from bit 10. Bit 11 is cleared by writing 1, and a set wins over a clear in the same cycle.
- R8: Port i answers at byte address BASE_ADDR + ADDR_STRIDE*i. Any other address reads 0, and a write to it changes no port.
- R9: After reset every stored bit is 0. The word reads as 0x0080 plus the live bits, and all PHY control outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe for the addressed register |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data of the addressed register, 0 if unmapped |
| phy_connect_i | input | NUM_PORTS | Device present, per port |
| phy_dp_i | input | NUM_PORTS | D+ line level, per port |
| phy_dm_i | input | NUM_PORTS | D- line level, per port |
| phy_resume_i | input | NUM_PORTS | Resume signalling seen, per port |
| phy_overcur_i | input | NUM_PORTS | Over-current condition, per port |
| phy_lowspeed_i | input | NUM_PORTS | Low-speed device detected, per port |
| port_en_o | output | NUM_PORTS | Port enable to PHY |
| port_rst_o | output | NUM_PORTS | Port reset drive to PHY |
| port_susp_o | output | NUM_PORTS | Port suspend drive to PHY |

## Verification
The bench builds the block with its defaults: two ports at byte offsets 16 and 18, and an 8-bit address. With these values both ports can be addressed together with the unmapped neighbours 14 and 20, plus random addresses. Two ports also let the bench confirm that events and writes on one port never disturb the other. Random writes are mixed with connect and over-current edges, so flag sets and write-one clears collide in the same cycle. Directed steps cover a disconnect and an over-current onset that each race a software enable.

// File: rtl/usb_portsc_pkg.sv
package usb_portsc_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned B_CONN   = 0;
  localparam int unsigned B_CONN_C = 1;
  localparam int unsigned B_EN     = 2;
  localparam int unsigned B_EN_C   = 3;
  localparam int unsigned B_DP     = 4;
  localparam int unsigned B_DM     = 5;
  localparam int unsigned B_RESUME = 6;
  localparam int unsigned B_ONE    = 7;
  localparam int unsigned B_LS     = 8;
  localparam int unsigned B_RST    = 9;
  localparam int unsigned B_OC     = 10;
  localparam int unsigned B_OC_C   = 11;
  localparam int unsigned B_SUSP   = 12;
endpackage

// File: rtl/usb_port_addr_dec.sv
module usb_port_addr_dec #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 16,
  parameter int unsigned ADDR_STRIDE = 2
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_PORTS-1:0] sel_o
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
    localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(BASE_ADDR + ADDR_STRIDE * g);
    assign sel_o[g] = (addr_i == PortAddr);
  end
endmodule

// File: rtl/usb_port_ctrl.sv
module usb_port_ctrl
  import usb_portsc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              connect_i,
  input  logic              dp_i,
  input  logic              dm_i,
  input  logic              resume_i,
  input  logic              overcur_i,
  input  logic              lowspeed_i,
  output logic [WORD_W-1:0] status_o,
  output logic              en_o,
  output logic              rst_o,
  output logic              susp_o
);
  logic conn_q, conn_c_q, en_q, en_c_q, oc_q, oc_c_q, rst_q, susp_q;
  logic en_d, disc_evt, oc_evt;

  assign disc_evt = conn_q & ~connect_i;
  assign oc_evt   = overcur_i & ~oc_q;

  // hardware disable overrides a software write
  always_comb begin
    en_d = en_q;
    if (wr_i) en_d = wdata_i[B_EN];
    if (disc_evt || oc_evt) en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conn_q   <= 1'b0;
      conn_c_q <= 1'b0;
      en_q     <= 1'b0;
      en_c_q   <= 1'b0;
      oc_q     <= 1'b0;
      oc_c_q   <= 1'b0;
      rst_q    <= 1'b0;
      susp_q   <= 1'b0;
    end else begin
      conn_q   <= connect_i;
      oc_q     <= overcur_i;
      en_q     <= en_d;
      // set beats write-one-to-clear
      conn_c_q <= (connect_i != conn_q) | (conn_c_q & ~(wr_i & wdata_i[B_CONN_C]));
      en_c_q   <= (en_d != en_q)        | (en_c_q   & ~(wr_i & wdata_i[B_EN_C]));
      oc_c_q   <= (overcur_i != oc_q)   | (oc_c_q   & ~(wr_i & wdata_i[B_OC_C]));
      if (wr_i) begin
        rst_q  <= wdata_i[B_RST];
        susp_q <= wdata_i[B_SUSP];
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[B_CONN]   = conn_q;
    status_o[B_CONN_C] = conn_c_q;
    status_o[B_EN]     = en_q;
    status_o[B_EN_C]   = en_c_q;
    status_o[B_DP]     = dp_i;
    status_o[B_DM]     = dm_i;
    status_o[B_RESUME] = resume_i;
    status_o[B_ONE]    = 1'b1;
    status_o[B_LS]     = lowspeed_i;
    status_o[B_RST]    = rst_q;
    status_o[B_OC]     = oc_q;
    status_o[B_OC_C]   = oc_c_q;
    status_o[B_SUSP]   = susp_q;
  end

  assign en_o   = en_q;
  assign rst_o  = rst_q;
  assign susp_o = susp_q;
endmodule

// File: rtl/usb_port_sc_regs.sv
module usb_port_sc_regs
  import usb_portsc_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 16,
  parameter int unsigned ADDR_STRIDE = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_wr_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [15:0]          bus_wdata_i,
  output logic [15:0]          bus_rdata_o,
  input  logic [NUM_PORTS-1:0] phy_connect_i,
  input  logic [NUM_PORTS-1:0] phy_dp_i,
  input  logic [NUM_PORTS-1:0] phy_dm_i,
  input  logic [NUM_PORTS-1:0] phy_resume_i,
  input  logic [NUM_PORTS-1:0] phy_overcur_i,
  input  logic [NUM_PORTS-1:0] phy_lowspeed_i,
  output logic [NUM_PORTS-1:0] port_en_o,
  output logic [NUM_PORTS-1:0] port_rst_o,
  output logic [NUM_PORTS-1:0] port_susp_o
);
  logic [NUM_PORTS-1:0] sel;
  logic [WORD_W-1:0]    status [NUM_PORTS];

  usb_port_addr_dec #(
    .NUM_PORTS  (NUM_PORTS),
    .ADDR_W     (ADDR_W),
    .BASE_ADDR  (BASE_ADDR),
    .ADDR_STRIDE(ADDR_STRIDE)
  ) i_addr_dec (
    .addr_i(bus_addr_i),
    .sel_o (sel)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    usb_port_ctrl i_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (bus_wr_i & sel[g]),
      .wdata_i   (bus_wdata_i),
      .connect_i (phy_connect_i[g]),
      .dp_i      (phy_dp_i[g]),
      .dm_i      (phy_dm_i[g]),
      .resume_i  (phy_resume_i[g]),
      .overcur_i (phy_overcur_i[g]),
      .lowspeed_i(phy_lowspeed_i[g]),
      .status_o  (status[g]),
      .en_o      (port_en_o[g]),
      .rst_o     (port_rst_o[g]),
      .susp_o    (port_susp_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (sel[i]) bus_rdata_o = bus_rdata_o | status[i];
    end
  end
endmodule

// File: rtl/usb_port_sc_regs_chk.sv
module usb_port_sc_regs_chk #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned BASE_ADDR   = 16,
  parameter int unsigned ADDR_STRIDE = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_wr_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [15:0]          bus_wdata_i,
  input logic [15:0]          bus_rdata_o,
  input logic [NUM_PORTS-1:0] phy_connect_i,
  input logic [NUM_PORTS-1:0] phy_dp_i,
  input logic [NUM_PORTS-1:0] phy_overcur_i,
  input logic [NUM_PORTS-1:0] port_en_o,
  input logic [NUM_PORTS-1:0] port_rst_o,
  input logic [NUM_PORTS-1:0] port_susp_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[15:13] == 3'b000); // R5

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
    localparam logic [ADDR_W-1:0] PortAddr = ADDR_W'(BASE_ADDR + ADDR_STRIDE * g);

    AST_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == PortAddr) |-> bus_rdata_o[7]); // R5

    AST_DP_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_addr_i == PortAddr) |-> (bus_rdata_o[4] == phy_dp_i[g])); // R1

    AST_DISC_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(phy_connect_i[g]) |=> !port_en_o[g]); // R3

    AST_OC_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(phy_overcur_i[g]) |=> !port_en_o[g]); // R3

    AST_RST_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_wr_i && bus_addr_i == PortAddr) |=>
        (port_rst_o[g] == $past(bus_wdata_i[9]))); // R6

    AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_wr_i && bus_addr_i == PortAddr) |=> $stable(port_susp_o[g])); // R8
  end
endmodule

bind usb_port_sc_regs usb_port_sc_regs_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .ADDR_W     (ADDR_W),
  .BASE_ADDR  (BASE_ADDR),
  .ADDR_STRIDE(ADDR_STRIDE)
) i_usb_port_sc_regs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i),
  .bus_rdata_o  (bus_rdata_o),
  .phy_connect_i(phy_connect_i),
  .phy_dp_i     (phy_dp_i),
  .phy_overcur_i(phy_overcur_i),
  .port_en_o    (port_en_o),
  .port_rst_o   (port_rst_o),
  .port_susp_o  (port_susp_o)
);

// File: tb/test_usb_port_sc_regs.sv
`timescale 1ns/1ps
module test_usb_port_sc_regs;
  localparam int NP = 2;
  localparam int AW = 8;
  localparam int BASE = 16;
  localparam int STRIDE = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          bus_wr_i = 1'b0;
  logic [AW-1:0] bus_addr_i = '0;
  logic [15:0]   bus_wdata_i = '0;
  logic [15:0]   bus_rdata_o;
  logic [NP-1:0] con = '0, dp = '0, dm = '0, res = '0, oc = '0, ls = '0;
  logic [NP-1:0] port_en_o, port_rst_o, port_susp_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of stored state
  bit m_conn[NP], m_csc[NP], m_pe[NP], m_pec[NP], m_oc[NP], m_occ[NP], m_rst[NP], m_susp[NP];

  always #5 clk_i = ~clk_i;

  usb_port_sc_regs #(.NUM_PORTS(NP), .ADDR_W(AW), .BASE_ADDR(BASE), .ADDR_STRIDE(STRIDE))
  i_usb_port_sc_regs (
    .clk_i, .rst_ni, .bus_wr_i, .bus_addr_i, .bus_wdata_i, .bus_rdata_o,
    .phy_connect_i(con), .phy_dp_i(dp), .phy_dm_i(dm), .phy_resume_i(res),
    .phy_overcur_i(oc), .phy_lowspeed_i(ls),
    .port_en_o, .port_rst_o, .port_susp_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int port_of(input int a);
    for (int p = 0; p < NP; p++) if (a == BASE + STRIDE * p) return p;
    return -1;
  endfunction

  task automatic check_outputs();
    for (int p = 0; p < NP; p++) begin
      chk("R3 port_en_o", int'(port_en_o[p]), int'(m_pe[p]));
      chk("R6 port_rst_o", int'(port_rst_o[p]), int'(m_rst[p]));
      chk("R6 port_susp_o", int'(port_susp_o[p]), int'(m_susp[p]));
    end
  endtask

  task automatic check_read();
    int p = port_of(int'(bus_addr_i));
    logic [15:0] r = bus_rdata_o;
    if (p < 0) begin
      chk("R8 unmapped read", int'(r), 0);
      return;
    end
    chk("R1 live dp", int'(r[4]), int'(dp[p]));
    chk("R1 live dm", int'(r[5]), int'(dm[p]));
    chk("R1 live resume", int'(r[6]), int'(res[p]));
    chk("R1 live lowspeed", int'(r[8]), int'(ls[p]));
    chk("R2 connect", int'(r[0]), int'(m_conn[p]));
    chk("R2 connect change", int'(r[1]), int'(m_csc[p]));
    chk("R3 enable", int'(r[2]), int'(m_pe[p]));
    chk("R4 enable change", int'(r[3]), int'(m_pec[p]));
    chk("R5 bit7 one", int'(r[7]), 1);
    chk("R5 bits15_13 zero", int'(r[15:13]), 0);
    chk("R6 reset bit", int'(r[9]), int'(m_rst[p]));
    chk("R6 suspend bit", int'(r[12]), int'(m_susp[p]));
    chk("R7 overcurrent", int'(r[10]), int'(m_oc[p]));
    chk("R7 overcurrent change", int'(r[11]), int'(m_occ[p]));
  endtask

  task automatic model_step();
    int sel = port_of(int'(bus_addr_i));
    for (int p = 0; p < NP; p++) begin
      bit w = bus_wr_i && (sel == p);
      bit pe_n = m_pe[p];
      if (w) pe_n = bus_wdata_i[2];
      if ((m_conn[p] && !con[p]) || (oc[p] && !m_oc[p])) pe_n = 0;
      m_csc[p] = (con[p] != m_conn[p]) || (m_csc[p] && !(w && bus_wdata_i[1]));
      m_pec[p] = (pe_n != m_pe[p]) || (m_pec[p] && !(w && bus_wdata_i[3]));
      m_occ[p] = (oc[p] != m_oc[p]) || (m_occ[p] && !(w && bus_wdata_i[11]));
      m_pe[p] = pe_n;
      m_conn[p] = con[p];
      m_oc[p] = oc[p];
      if (w) begin
        m_rst[p] = bus_wdata_i[9];
        m_susp[p] = bus_wdata_i[12];
      end
    end
  endtask

  // one clock: check state, apply stimulus, check read, advance model
  task automatic cyc(input logic [NP-1:0] c, input logic [NP-1:0] o, input bit wr,
                     input int a, input logic [15:0] wd);
    @(negedge clk_i);
    check_outputs();
    con = c; oc = o; bus_wr_i = wr; bus_addr_i = AW'(a); bus_wdata_i = wd;
    #1;
    check_read();
    model_step();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int p = 0; p < NP; p++) begin
      m_conn[p] = 0; m_csc[p] = 0; m_pe[p] = 0; m_pec[p] = 0;
      m_oc[p] = 0; m_occ[p] = 0; m_rst[p] = 0; m_susp[p] = 0;
    end
    repeat (3) @(negedge clk_i);
    // R9: reset state
    check_outputs();
    bus_addr_i = AW'(BASE); #1;
    chk("R9 reset read", int'(bus_rdata_o), 16'h0080);
    rst_ni = 1'b1;

    // directed corners
    cyc(2'b01, 2'b00, 0, BASE, 0);             // connect port0 -> R2 change
    cyc(2'b01, 2'b00, 1, BASE, 16'h0000);      // R2 write 0 keeps flag
    cyc(2'b01, 2'b00, 1, BASE, 16'hE004);      // R3 enable, R5 reserved writes
    cyc(2'b01, 2'b00, 1, BASE, 16'h000E);      // R2/R4 W1C, keep enable
    cyc(2'b00, 2'b00, 1, BASE, 16'h0004);      // R3 disconnect beats write
    cyc(2'b01, 2'b00, 1, BASE, 16'h000A);      // R2 set wins over clear
    cyc(2'b01, 2'b00, 1, BASE, 16'h1204);      // R6 reset+suspend, enable
    cyc(2'b01, 2'b01, 1, BASE, 16'h1204);      // R3/R7 over-current beats write
    cyc(2'b01, 2'b01, 1, BASE, 16'h0800);      // R7 clear change
    cyc(2'b01, 2'b01, 1, BASE + STRIDE, 16'h1200); // R8 port1 only
    cyc(2'b01, 2'b01, 1, BASE + 2 * STRIDE, 16'hFFFF); // R8 unmapped write
    cyc(2'b01, 2'b01, 0, BASE - STRIDE, 0);    // R8 unmapped read
    cyc(2'b01, 2'b01, 0, BASE, 0);

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      logic [NP-1:0] c = con, o = oc;
      int a;
      int r = int'($urandom_range(0, 9));
      for (int p = 0; p < NP; p++) begin
        if ($urandom_range(0, 7) == 0) c[p] = ~c[p];
        if ($urandom_range(0, 15) == 0) o[p] = ~o[p];
      end
      dp = NP'($urandom); dm = NP'($urandom); res = NP'($urandom); ls = NP'($urandom);
      if (r < 8) a = BASE + STRIDE * (r % NP);
      else if (r == 8) a = BASE + STRIDE * NP;
      else a = int'($urandom_range(0, (1 << AW) - 1));
      cyc(c, o, $urandom_range(0, 2) == 0, a, 16'($urandom));
    end

    @(negedge clk_i);
    check_outputs();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule